// File: doc/BRIEF.md
# Thermal Sensor Auto-Scan Controller

This block polls up to four temperature-sensor channels through one shared ADC. While automatic scanning is enabled, it starts one conversion per idle interval, visiting the enabled channels in ascending order and wrapping around. It stores each result in a per-channel reading register. It then compares the result against two thresholds for that channel: one for the interrupt and one for shutdown.

An alarm is raised only after the reading has exceeded its threshold on a programmed number of consecutive samples. The interrupt and the shutdown each keep their own count. A sense bit decides whether a larger code or a smaller code means hotter. When any enabled channel is over either threshold, the controller switches to a shorter, high-temperature interval. It goes back to the normal interval once every enabled channel is below both thresholds.

Software uses a simple synchronous register bus. Writes are single-cycle strobes, and reads are combinational on the address. The block drives three outputs:
- a level interrupt;
- a shutdown request to the reset/clock unit;
- a shutdown pin with selectable polarity.

The ADC is replaced by a start/done handshake that returns a 10-bit code.

Top module: `therm_scan`

## Requirements
- R1: After reset: interrupt and reset/clock shutdown are low, the shutdown pin sits at its inactive level (1, because the polarity bit resets to 0 = active-low), every reading and pending bit reads 0, and no conversion starts.
- R2: Conversions start only while auto-enable (bit 0 at 0x04) is 1 and at least one channel enable (bits 4..7 at 0x04, bit 4+c for channel c) is 1. Each start is a one-cycle pulse on `adcStart`, with the channel number on `adcChan`.
- R3: Enabled channels are converted in ascending index order, wrapping from the highest enabled channel to the lowest, and disabled channels are skipped.
- R4: The code present when `adcDone` is high is stored in the reading register of the converting channel, at 0x20 + 4·c.
- R5: While no enabled channel is over a threshold, the next `adcStart` rises exactly P+1 cycles after the cycle in which `adcDone` was accepted. P is the normal period at 0x68.
- R6: If the latest reading of any enabled channel exceeds its interrupt threshold (0x30 + 4·c) or its shutdown threshold (0x40 + 4·c), the high-temperature period H at 0x6C is used instead, giving a gap of H+1. The normal period returns once no enabled channel is over either threshold.
- R7: Interrupt-pending bit c (bit c of 0x0C) sets on the sample on which the channel's consecutive-exceed count reaches the interrupt debounce value at 0x60. A non-exceeding reading resets that count to zero.
- R8: Shutdown-pending bit c (bit 4+c of 0x0C) uses its own consecutive count against the shutdown debounce value at 0x64, independently of the interrupt count.
- R9: Sense bit 1 of 0x04 sets the comparison direction. With 1, a reading exceeds when code > threshold; with 0, when code < threshold.
- R10: Pending bits are cleared by writing 1 to them, and writing 0 leaves them unchanged. `thermIrq` is the OR of interrupt-pending bits masked by interrupt enables (bits 0..3 at 0x08).
- R11: `shutCru` is the OR of shutdown-pending bits masked by bits 8..11 at 0x08. The pin is active when a shutdown-pending bit is masked in by bits 4..7 at 0x08. The pin level is high when active if polarity bit 8 of 0x04 is 1, and low when active if it is 0.
- R12: Sticky bit 24 of 0x04 sets while any shutdown-pending bit is set. It stays set after those bits clear, and is cleared only by writing 1 to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 8 | Register byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr |
| adcStart | output | 1 | One-cycle conversion request |
| adcChan | output | 2 | Channel being converted |
| adcDone | input | 1 | Conversion result valid |
| adcCode | input | 10 | Conversion result |
| thermIrq | output | 1 | Level interrupt |
| shutCru | output | 1 | Shutdown request to reset/clock unit |
| shutPin | output | 1 | Shutdown pin, polarity selectable |

## Verification
The bench builds the block with its default widths: 10-bit codes, 8-bit debounce counters and 24-bit period counters. It then programs periods of only 3 to 20 cycles, so that many samples fit in a short run. This lets the bench measure the exact start-to-done gap in both the normal and the high-temperature interval. It also lets the bench step a single channel through exceed, miss and exceed sequences, one sample at a time, to find the exact sample on which each debounced pending bit sets.

// File: rtl/therm_scan_pkg.sv
package therm_scan_pkg;
  localparam int NUM_CH   = 4;
  localparam int CH_IDX_W = 2;
  localparam int DATA_W   = 32;

  localparam int A_AUTO   = 'h04;
  localparam int A_INTEN  = 'h08;
  localparam int A_PEND   = 'h0C;
  localparam int A_READ   = 'h20;
  localparam int A_ITHR   = 'h30;
  localparam int A_STHR   = 'h40;
  localparam int A_IDEB   = 'h60;
  localparam int A_SDEB   = 'h64;
  localparam int A_NPER   = 'h68;
  localparam int A_HPER   = 'h6C;

  typedef enum logic [2:0] {sIdle, sStart, sBusy, sGap, sWait} scanState_e;

  typedef struct packed {
    logic                capture;
    logic [CH_IDX_W-1:0] chan;
  } scanStrobe_t;
endpackage

// File: rtl/therm_scan_ctrl.sv
module therm_scan_ctrl
  import therm_scan_pkg::*;
#(
  parameter int PER_W = 24
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                autoEn,
  input  logic [NUM_CH-1:0]   chanEn,
  input  logic                hot,
  input  logic [PER_W-1:0]    normPer,
  input  logic [PER_W-1:0]    hotPer,
  input  logic                adcDone,
  output logic                adcStart,
  output logic [CH_IDX_W-1:0] adcChan,
  output scanStrobe_t         strobe
);
  scanState_e          state;
  logic [CH_IDX_W-1:0] curChan;
  logic [CH_IDX_W-1:0] lowChan;
  logic [CH_IDX_W-1:0] nextChan;
  logic [PER_W-1:0]    timer;
  logic                runOk;

  assign runOk = autoEn && (|chanEn);

  // lowest enabled channel, used when leaving idle
  always_comb begin
    lowChan = '0;
    for (int k = NUM_CH - 1; k >= 0; k--)
      if (chanEn[k]) lowChan = CH_IDX_W'(k);
  end

  // next enabled channel above the current one, wrapping
  always_comb begin
    nextChan = curChan;
    for (int k = NUM_CH - 1; k >= 1; k--)
      if (chanEn[(int'(curChan) + k) % NUM_CH])
        nextChan = CH_IDX_W'((int'(curChan) + k) % NUM_CH);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= sIdle;
      curChan <= '0;
      timer   <= '0;
    end else begin
      unique case (state)
        sIdle: if (runOk) begin
          curChan <= lowChan;
          state   <= sStart;
        end
        sStart: state <= sBusy;
        sBusy:  if (adcDone) state <= sGap;
        sGap: begin
          if (!runOk) state <= sIdle;
          else begin
            timer   <= hot ? hotPer : normPer;
            curChan <= nextChan;
            state   <= sWait;
          end
        end
        sWait: begin
          if (!runOk) state <= sIdle;
          else if (timer <= PER_W'(1)) begin
            state <= sStart;
            if (!chanEn[curChan]) curChan <= nextChan;
          end else timer <= timer - 1'b1;
        end
        default: state <= sIdle;
      endcase
    end
  end

  assign adcStart       = (state == sStart);
  assign adcChan        = curChan;
  assign strobe.capture = (state == sBusy) && adcDone;
  assign strobe.chan    = curChan;
endmodule

// File: rtl/therm_scan_dp.sv
module therm_scan_dp
  import therm_scan_pkg::*;
#(
  parameter int CODE_W = 10,
  parameter int DEB_W  = 8,
  parameter int PER_W  = 24,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [CODE_W-1:0] adcCode,
  input  scanStrobe_t       strobe,
  output logic              autoEn,
  output logic [NUM_CH-1:0] chanEn,
  output logic [PER_W-1:0]  normPer,
  output logic [PER_W-1:0]  hotPer,
  output logic              hot,
  output logic              thermIrq,
  output logic              shutCru,
  output logic              shutPin,
  output logic [NUM_CH-1:0] irqPendVec,
  output logic [NUM_CH-1:0] shutPendVec
);
  logic              senseHi, shutActHi, lastShut;
  logic [NUM_CH-1:0] irqEn, pinEn, cruEn, overVec;
  logic [DEB_W-1:0]  irqDeb, shutDeb, irqDebEff, shutDebEff;
  logic [CODE_W-1:0] readingArr [NUM_CH];
  logic              wrAuto, wrInten, wrPend;

  assign wrAuto  = busWr && (busAddr == ADDR_W'(A_AUTO));
  assign wrInten = busWr && (busAddr == ADDR_W'(A_INTEN));
  assign wrPend  = busWr && (busAddr == ADDR_W'(A_PEND));

  assign irqDebEff  = (irqDeb  == '0) ? DEB_W'(1) : irqDeb;
  assign shutDebEff = (shutDeb == '0) ? DEB_W'(1) : shutDeb;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      autoEn <= 1'b0; senseHi <= 1'b0; shutActHi <= 1'b0; chanEn <= '0;
      irqEn <= '0; pinEn <= '0; cruEn <= '0;
      irqDeb <= '0; shutDeb <= '0; normPer <= '0; hotPer <= '0;
    end else if (busWr) begin
      if (wrAuto) begin
        autoEn    <= busWdata[0];
        senseHi   <= busWdata[1];
        chanEn    <= busWdata[4 +: NUM_CH];
        shutActHi <= busWdata[8];
      end
      if (wrInten) begin
        irqEn <= busWdata[0 +: NUM_CH];
        pinEn <= busWdata[4 +: NUM_CH];
        cruEn <= busWdata[8 +: NUM_CH];
      end
      if (busAddr == ADDR_W'(A_IDEB)) irqDeb  <= busWdata[DEB_W-1:0];
      if (busAddr == ADDR_W'(A_SDEB)) shutDeb <= busWdata[DEB_W-1:0];
      if (busAddr == ADDR_W'(A_NPER)) normPer <= busWdata[PER_W-1:0];
      if (busAddr == ADDR_W'(A_HPER)) hotPer  <= busWdata[PER_W-1:0];
    end
  end

  // sticky record of any shutdown event
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lastShut <= 1'b0;
    else if (|shutPendVec) lastShut <= 1'b1;
    else if (wrAuto && busWdata[24]) lastShut <= 1'b0;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [CODE_W-1:0] reading, irqThr, shutThr;
    logic [DEB_W-1:0]  irqCnt, shutCnt, irqCntInc, shutCntInc;
    logic              irqOver, shutOver, hit, irqPendQ, shutPendQ, overQ;

    assign hit        = strobe.capture && (strobe.chan == CH_IDX_W'(c));
    assign irqOver    = senseHi ? (adcCode > irqThr)  : (adcCode < irqThr);
    assign shutOver   = senseHi ? (adcCode > shutThr) : (adcCode < shutThr);
    assign irqCntInc  = (&irqCnt)  ? irqCnt  : irqCnt + 1'b1;
    assign shutCntInc = (&shutCnt) ? shutCnt : shutCnt + 1'b1;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        reading <= '0; irqThr <= '1; shutThr <= '1;
        irqCnt <= '0; shutCnt <= '0; overQ <= 1'b0;
      end else begin
        if (busWr && busAddr == ADDR_W'(A_ITHR + 4 * c)) irqThr  <= busWdata[CODE_W-1:0];
        if (busWr && busAddr == ADDR_W'(A_STHR + 4 * c)) shutThr <= busWdata[CODE_W-1:0];
        if (hit) begin
          reading <= adcCode;
          irqCnt  <= irqOver  ? irqCntInc  : '0;
          shutCnt <= shutOver ? shutCntInc : '0;
          overQ   <= irqOver | shutOver;
        end
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        irqPendQ  <= 1'b0;
        shutPendQ <= 1'b0;
      end else begin
        if (hit && irqOver && irqCntInc >= irqDebEff) irqPendQ <= 1'b1;
        else if (wrPend && busWdata[c]) irqPendQ <= 1'b0;
        if (hit && shutOver && shutCntInc >= shutDebEff) shutPendQ <= 1'b1;
        else if (wrPend && busWdata[4 + c]) shutPendQ <= 1'b0;
      end
    end

    assign readingArr[c]  = reading;
    assign irqPendVec[c]  = irqPendQ;
    assign shutPendVec[c] = shutPendQ;
    assign overVec[c]     = overQ;
  end

  assign hot      = |(overVec & chanEn);
  assign thermIrq = |(irqPendVec & irqEn);
  assign shutCru  = |(shutPendVec & cruEn);
  assign shutPin  = shutActHi ? (|(shutPendVec & pinEn)) : !(|(shutPendVec & pinEn));

  always_comb begin
    busRdata = '0;
    unique case (busAddr)
      ADDR_W'(A_AUTO):  busRdata = {7'b0, lastShut, 15'b0, shutActHi, chanEn, 2'b0, senseHi, autoEn};
      ADDR_W'(A_INTEN): busRdata = DATA_W'({cruEn, pinEn, irqEn});
      ADDR_W'(A_PEND):  busRdata = DATA_W'({shutPendVec, irqPendVec});
      ADDR_W'(A_IDEB):  busRdata = DATA_W'(irqDeb);
      ADDR_W'(A_SDEB):  busRdata = DATA_W'(shutDeb);
      ADDR_W'(A_NPER):  busRdata = DATA_W'(normPer);
      ADDR_W'(A_HPER):  busRdata = DATA_W'(hotPer);
      default:          busRdata = '0;
    endcase
    for (int c = 0; c < NUM_CH; c++)
      if (busAddr == ADDR_W'(A_READ + 4 * c)) busRdata = DATA_W'(readingArr[c]);
  end
endmodule

// File: rtl/therm_scan.sv
module therm_scan
  import therm_scan_pkg::*;
#(
  parameter int CODE_W = 10,
  parameter int DEB_W  = 8,
  parameter int PER_W  = 24,
  parameter int ADDR_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWr,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W-1:0]   busRdata,
  output logic                adcStart,
  output logic [CH_IDX_W-1:0] adcChan,
  input  logic                adcDone,
  input  logic [CODE_W-1:0]   adcCode,
  output logic                thermIrq,
  output logic                shutCru,
  output logic                shutPin
);
  scanStrobe_t       strobe;
  logic              autoEn, hot;
  logic [NUM_CH-1:0] chanEn, irqPendVec, shutPendVec;
  logic [PER_W-1:0]  normPer, hotPer;

  therm_scan_ctrl #(.PER_W(PER_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .autoEn(autoEn), .chanEn(chanEn), .hot(hot),
    .normPer(normPer), .hotPer(hotPer), .adcDone(adcDone),
    .adcStart(adcStart), .adcChan(adcChan), .strobe(strobe)
  );

  therm_scan_dp #(.CODE_W(CODE_W), .DEB_W(DEB_W), .PER_W(PER_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .adcCode(adcCode), .strobe(strobe), .autoEn(autoEn),
    .chanEn(chanEn), .normPer(normPer), .hotPer(hotPer), .hot(hot),
    .thermIrq(thermIrq), .shutCru(shutCru), .shutPin(shutPin),
    .irqPendVec(irqPendVec), .shutPendVec(shutPendVec)
  );
endmodule

// File: rtl/therm_scan_chk.sv
module therm_scan_chk
  import therm_scan_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              adcStart,
  input logic              adcDone,
  input logic              busWr,
  input logic              thermIrq,
  input logic              shutCru,
  input logic [NUM_CH-1:0] irqPendVec,
  input logic [NUM_CH-1:0] shutPendVec
);
  // R2: each start request lasts exactly one cycle
  a_r2_start_single: assert property (@(posedge clk) disable iff (!rstN)
    adcStart |=> !adcStart);

  // R7: a newly set interrupt-pending bit always follows an accepted sample
  a_r7_pend_from_sample: assert property (@(posedge clk) disable iff (!rstN)
    (|(irqPendVec & ~$past(irqPendVec))) |-> $past(adcDone));

  // R8: a newly set shutdown-pending bit always follows an accepted sample
  a_r8_shut_from_sample: assert property (@(posedge clk) disable iff (!rstN)
    (|(shutPendVec & ~$past(shutPendVec))) |-> $past(adcDone));

  // R10: the interrupt rises only after a sample or a register write
  a_r10_irq_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(thermIrq) |-> ($past(adcDone) || $past(busWr)));

  // R11: the reset/clock shutdown is released only by software
  a_r11_cru_release: assert property (@(posedge clk) disable iff (!rstN)
    $fell(shutCru) |-> $past(busWr));
endmodule

bind therm_scan therm_scan_chk u_chk (
  .clk(clk), .rstN(rstN), .adcStart(adcStart), .adcDone(adcDone), .busWr(busWr),
  .thermIrq(thermIrq), .shutCru(shutCru), .irqPendVec(irqPendVec),
  .shutPendVec(shutPendVec)
);

// File: tb/therm_scan_tb.sv
module therm_scan_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        adcStart;
  logic [1:0]  adcChan;
  logic        adcDone = 1'b0;
  logic [9:0]  adcCode = '0;
  logic        thermIrq, shutCru, shutPin;

  int checks = 0, errors = 0, cyc = 0;
  int nStarts = 0, nDones = 0, lastDoneEdge = 0;
  int chanLog [64];
  int gapLog  [64];
  logic [9:0] codeFor [4];
  bit finished = 0;

  therm_scan u_dut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .adcStart(adcStart), .adcChan(adcChan), .adcDone(adcDone),
    .adcCode(adcCode), .thermIrq(thermIrq), .shutCru(shutCru), .shutPin(shutPin)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc++;

  // ADC stand-in: done two cycles after each start
  initial begin
    forever begin
      @(negedge clk);
      if (adcStart) begin
        int ch;
        ch = adcChan;
        if (nStarts < 64) begin
          chanLog[nStarts] = ch;
          gapLog[nStarts]  = cyc - lastDoneEdge;
        end
        nStarts++;
        @(negedge clk);
        @(negedge clk);
        adcCode = codeFor[ch];
        adcDone = 1'b1;
        lastDoneEdge = cyc + 1;
        nDones++;
        @(negedge clk);
        adcDone = 1'b0;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  function automatic logic [31:0] autoWord(input bit en, input bit sense,
                                           input logic [3:0] chans, input bit polHi);
    return {23'b0, polHi, chans, 2'b0, sense, en};
  endfunction

  task automatic waitStarts(input int target);
    while (nStarts < target) @(negedge clk);
  endtask

  task automatic waitDone();
    int t;
    t = nDones + 1;
    while (nDones < t) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic stopScan(input logic [3:0] chans, input bit sense);
    busWrite(8'h04, autoWord(0, sense, chans, 0));
    repeat (30) @(negedge clk);
  endtask

  task automatic testReset();
    logic [31:0] d;
    check("R1 irq low", thermIrq, 0);
    check("R1 cru low", shutCru, 0);
    check("R1 pin inactive", shutPin, 1);
    busRead(8'h20, d); check("R1 reading0", d, 0);
    busRead(8'h0C, d); check("R1 pending", d, 0);
    busWrite(8'h04, autoWord(0, 0, 4'hF, 0));
    repeat (20) @(negedge clk);
    check("R2 no start without auto-enable", nStarts, 0);
  endtask

  task automatic testRoundRobin();
    logic [31:0] d;
    codeFor[0] = 10'd100; codeFor[2] = 10'd200; codeFor[3] = 10'd300;
    busWrite(8'h68, 5); busWrite(8'h6C, 5);
    nStarts = 0;
    busWrite(8'h04, autoWord(1, 1, 4'b1101, 0));
    waitStarts(6);
    check("R3 order 0", chanLog[0], 0);
    check("R3 order 1", chanLog[1], 2);
    check("R3 order 2", chanLog[2], 3);
    check("R3 wrap", chanLog[3], 0);
    check("R3 order 4", chanLog[4], 2);
    for (int i = 1; i < 6; i++) check("R5 normal gap", gapLog[i], 6);
    stopScan(4'b1101, 1);
    busRead(8'h20, d); check("R4 reading0", d, 100);
    busRead(8'h28, d); check("R4 reading2", d, 200);
    busRead(8'h2C, d); check("R4 reading3", d, 300);
    busRead(8'h24, d); check("R4 reading1 untouched", d, 0);
  endtask

  task automatic testHotPeriod();
    busWrite(8'h68, 20); busWrite(8'h6C, 4);
    busWrite(8'h30, 500); busWrite(8'h60, 15);
    codeFor[0] = 10'd600;
    nStarts = 0;
    busWrite(8'h04, autoWord(1, 1, 4'b0001, 0));
    waitStarts(3);
    codeFor[0] = 10'd100;
    check("R6 hot gap 1", gapLog[1], 5);
    check("R6 hot gap 2", gapLog[2], 5);
    waitStarts(5);
    check("R6 back to normal gap", gapLog[4], 21);
    stopScan(4'b0001, 1);
  endtask

  task automatic testDebounce();
    logic [31:0] d;
    busWrite(8'h0C, 32'hFF);
    busWrite(8'h34, 500); busWrite(8'h44, 550);
    busWrite(8'h60, 3); busWrite(8'h64, 1);
    busWrite(8'h08, 32'h200);
    busWrite(8'h68, 3); busWrite(8'h6C, 3);
    codeFor[1] = 10'd600;
    busWrite(8'h04, autoWord(1, 1, 4'b0010, 0));
    waitDone();
    busRead(8'h0C, d);
    check("R7 no irq after 1 sample", d[1], 0);
    check("R8 shutdown after 1 sample", d[5], 1);
    check("R11 cru asserted", shutCru, 1);
    waitDone();
    codeFor[1] = 10'd400;
    busRead(8'h0C, d); check("R7 no irq after 2 samples", d[1], 0);
    waitDone();
    codeFor[1] = 10'd600;
    busRead(8'h0C, d); check("R7 miss resets count", d[1], 0);
    waitDone(); waitDone();
    busRead(8'h0C, d); check("R7 count restarted", d[1], 0);
    waitDone();
    busRead(8'h0C, d); check("R7 irq after 3 consecutive", d[1], 1);
    stopScan(4'b0010, 1);
  endtask

  task automatic testIrqAndShut();
    logic [31:0] d;
    check("R10 masked irq", thermIrq, 0);
    busWrite(8'h08, 32'h202);
    check("R10 enabled irq", thermIrq, 1);
    busWrite(8'h0C, 32'h2);
    busRead(8'h0C, d); check("R10 w1c keeps others", d, 32'h20);
    check("R10 irq cleared", thermIrq, 0);
    check("R11 pin not routed", shutPin, 1);
    busWrite(8'h08, 32'h222);
    check("R11 pin active-low", shutPin, 0);
    busWrite(8'h04, autoWord(0, 1, 4'b0010, 1));
    check("R11 pin active-high", shutPin, 1);
    busRead(8'h04, d); check("R12 sticky set", d[24], 1);
    busWrite(8'h0C, 32'h20);
    check("R11 cru released", shutCru, 0);
    check("R11 pin idle active-high", shutPin, 0);
    busRead(8'h04, d); check("R12 sticky holds", d[24], 1);
    busWrite(8'h04, autoWord(0, 1, 4'b0010, 0) | 32'h0100_0000);
    busRead(8'h04, d); check("R12 sticky cleared", d[24], 0);
  endtask

  task automatic testSense();
    logic [31:0] d;
    busWrite(8'h38, 300); busWrite(8'h48, 0);
    busWrite(8'h60, 1); busWrite(8'h08, 32'h4);
    codeFor[2] = 10'd400;
    busWrite(8'h04, autoWord(1, 0, 4'b0100, 0));
    waitDone();
    busRead(8'h0C, d); check("R9 larger code not over when sense 0", d[2], 0);
    codeFor[2] = 10'd200;
    waitDone();
    busRead(8'h0C, d); check("R9 smaller code over when sense 0", d[2], 1);
    check("R10 irq from ch2", thermIrq, 1);
    stopScan(4'b0100, 0);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) codeFor[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRoundRobin();
    testHotPeriod();
    testDebounce();
    testIrqAndShut();
    testSense();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule